// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows the state of every bank in a four-bank graphics DRAM as commands go out to it. Each clock it takes a decoded command, a bank number and the shared address bit that means two different things. On a column access that bit asks for an automatic close of the row once the burst ends. On a close command it widens the close to every bank.

For each bank the block keeps a small state machine with a down-counter. The counter holds the bank in the open-row wait, in a burst, in an access that closes itself, or in the close wait, for a number of cycles set by parameters. Any command that the current bank states forbid is flagged with a one-cycle pulse on `violation`. Such a command changes no bank state. A controller can use the block as a legality guard, and a monitor on a memory bus can use it as a protocol checker.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank reports state 0 (idle) and `violation` is low. The per-bank codes are: 0 idle, 1 opening, 2 open, 3 reading, 4 writing, 5 reading then auto-closing, 6 writing then auto-closing, 7 closing. Bank i occupies `bank_state[3*i+2:3*i]`.
- R2: Command code 1 (activate) to an idle bank moves it to opening. The bank stays opening for exactly T_RCD cycles and then becomes open.
- R3: A read (code 2) or write (code 3) to a bank that is idle or opening is illegal.
- R4: A read or write with `cmd_a8` low to an open bank gives reading or writing. This lasts BURST_LEN/2 cycles, after which the bank is open again.
- R5: A read or write with `cmd_a8` high to an open bank gives state 5 or 6. This lasts BURST_LEN/2 + T_RP cycles, after which the bank is idle.
- R6: Any command addressed to a bank in states 1, 5, 6 or 7 is illegal.
- R7: A close (code 4) with `cmd_a8` low acts only on the bank given by `cmd_ba`. A bank in state 2, 3 or 4 becomes closing for T_RP cycles and then idle. An idle bank stays idle and no violation is raised.
- R8: A close with `cmd_a8` high ignores `cmd_ba` and acts on every bank. It is illegal if any bank is in state 1, 5, 6 or 7.
- R9: An illegal command raises `violation` for exactly the one cycle after the edge that registered it, and changes no bank state. NOP (code 0, and the unused codes 5 to 7) never raises it.
- R10: An activate to a bank in state 2, 3 or 4 is illegal.
- R11: A read or write to a bank that is reading or writing is legal. It restarts the burst with the new direction and auto-close setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Decoded command: 0 NOP, 1 activate, 2 read, 3 write, 4 close |
| cmd_ba | input | $clog2(NUM_BANKS) | Target bank |
| cmd_a8 | input | 1 | Auto-close on read/write; all-bank select on close |
| bank_state | output | 3*NUM_BANKS | Registered state code of every bank |
| violation | output | 1 | One-cycle pulse for an illegal command |

## Verification
The hardest situation to reach is one where a command lands on a bank exactly while another bank is held in a self-closing access. An all-bank close issued then must be refused as a whole. Random streams seldom build that combination, so a directed sequence first opens one bank, then starts an auto-closing write on a second, and issues the all-bank close inside that window. A long weighted-random stream then runs against a behavioural model, comparing every bank and the violation pulse on every clock to cover restart and timer-edge overlaps.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_RD      = 3'd3,
    BK_WR      = 3'd4,
    BK_RD_AC   = 3'd5,
    BK_WR_AC   = 3'd6,
    BK_CLOSING = 3'd7
  } bank_st_e;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  function automatic logic st_locked(input logic [2:0] s);
    return (s == BK_OPENING) || (s == BK_RD_AC) || (s == BK_WR_AC) || (s == BK_CLOSING);
  endfunction

  function automatic logic st_has_row(input logic [2:0] s);
    return (s == BK_OPEN) || (s == BK_RD) || (s == BK_WR);
  endfunction
endpackage

// File: rtl/dbt_legal.sv
module dbt_legal
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W = $clog2(NUM_BANKS)
) (
  input  logic [2:0]                 op,
  input  logic [BA_W-1:0]            ba,
  input  logic                       a8,
  input  logic [NUM_BANKS-1:0][2:0]  st_all,
  output logic [NUM_BANKS-1:0]       go,
  output logic                       illegal
);
  logic [NUM_BANKS-1:0] locked;
  logic [NUM_BANKS-1:0] has_row;
  logic [2:0]           sel_st;
  logic                 legal;
  logic                 all_tgt;
  logic                 one_tgt;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cls
    assign locked[i]  = st_locked(st_all[i]);
    assign has_row[i] = st_has_row(st_all[i]);
  end

  assign sel_st = st_all[ba];

  always_comb begin
    legal   = 1'b1;
    all_tgt = 1'b0;
    one_tgt = 1'b0;
    case (op)
      OP_ACT: begin
        legal   = (sel_st == BK_IDLE);
        one_tgt = 1'b1;
      end
      OP_RD, OP_WR: begin
        legal   = has_row[ba];
        one_tgt = 1'b1;
      end
      OP_PRE: begin
        if (a8) begin
          legal   = ~|locked;
          all_tgt = 1'b1;
        end else begin
          legal   = ~locked[ba];
          one_tgt = 1'b1;
        end
      end
      default: legal = 1'b1;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++)
      go[i] = legal & (all_tgt | (one_tgt & (ba == BA_W'(i))));
  end

  assign illegal = ~legal;
endmodule

// File: rtl/dbt_bank.sv
module dbt_bank
  import dbt_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_CYC = 2,
  parameter int CNT_W     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [2:0] op,
  input  logic       a8,
  output logic [2:0] st
);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] BST_LD = CNT_W'(BURST_CYC - 1);
  localparam logic [CNT_W-1:0] AC_LD  = CNT_W'(BURST_CYC + T_RP - 1);

  bank_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              timed;

  assign timed = (st_q != BK_IDLE) && (st_q != BK_OPEN);
  assign st    = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (go) begin
      case (op)
        OP_ACT: begin
          st_q  <= BK_OPENING;
          cnt_q <= RCD_LD;
        end
        OP_RD: begin
          st_q  <= a8 ? BK_RD_AC : BK_RD;
          cnt_q <= a8 ? AC_LD : BST_LD;
        end
        OP_WR: begin
          st_q  <= a8 ? BK_WR_AC : BK_WR;
          cnt_q <= a8 ? AC_LD : BST_LD;
        end
        OP_PRE: begin
          if (st_q != BK_IDLE) begin
            st_q  <= BK_CLOSING;
            cnt_q <= RP_LD;
          end
        end
        default: ;
      endcase
    end else if (timed) begin
      if (cnt_q == '0) begin
        case (st_q)
          BK_OPENING, BK_RD, BK_WR: st_q <= BK_OPEN;
          default:                  st_q <= BK_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R3
  idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_IDLE) |=> (st_q == BK_IDLE || st_q == BK_OPENING));

  // R2
  opening_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_OPENING) |=> (st_q == BK_OPENING || st_q == BK_OPEN));

  // R6
  autoclose_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_RD_AC || st_q == BK_WR_AC) |=> ($stable(st_q) || st_q == BK_IDLE));

  // R7
  closing_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_CLOSING) |=> (st_q == BK_CLOSING || st_q == BK_IDLE));
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2:0]             cmd_op,
  input  logic [BA_W-1:0]        cmd_ba,
  input  logic                   cmd_a8,
  output logic [3*NUM_BANKS-1:0] bank_state,
  output logic                   violation
);
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int MAX_WAIT  = (T_RCD > BURST_CYC + T_RP) ? T_RCD : BURST_CYC + T_RP;
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);

  logic [NUM_BANKS-1:0][2:0] st_all;
  logic [NUM_BANKS-1:0]      go;
  logic                      illegal;

  dbt_legal #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_legal (
    .op      (cmd_op),
    .ba      (cmd_ba),
    .a8      (cmd_a8),
    .st_all  (st_all),
    .go      (go),
    .illegal (illegal)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    dbt_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .BURST_CYC(BURST_CYC), .CNT_W(CNT_W)
    ) u_bank (
      .clk (clk),
      .rst (rst),
      .go  (go[i]),
      .op  (cmd_op),
      .a8  (cmd_a8),
      .st  (st_all[i])
    );
    assign bank_state[3*i +: 3] = st_all[i];
  end

  always_ff @(posedge clk) begin
    if (rst) violation <= 1'b0;
    else     violation <= illegal;
  end

  // R9
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    violation |-> ($past(cmd_op) inside {OP_ACT, OP_RD, OP_WR, OP_PRE}));

  // R7
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_op == OP_PRE && cmd_a8) |-> $onehot0(go));
endmodule

// File: tb/dram_bank_tracker_bench.sv
module dram_bank_tracker_bench;
  localparam int NB  = 4;
  localparam int RCD = 3;
  localparam int RP  = 3;
  localparam int BL  = 4;
  localparam int BC  = BL / 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       cmd_op = 3'd0;
  logic [1:0]       cmd_ba = 2'd0;
  logic             cmd_a8 = 1'b0;
  logic [3*NB-1:0]  bank_state;
  logic             violation;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int mst [NB];
  int mrem[NB];
  int mviol;

  dram_bank_tracker #(.NUM_BANKS(NB), .T_RCD(RCD), .T_RP(RP), .BURST_LEN(BL)) u_dram_bank_tracker (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_ba(cmd_ba), .cmd_a8(cmd_a8),
    .bank_state(bank_state), .violation(violation)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bst(input int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  function automatic bit locked(input int s);
    return s == 1 || s == 5 || s == 6 || s == 7;
  endfunction

  // behavioural reference: remaining-cycle counts per bank
  task automatic model_step(input int op, input int b, input int a8);
    bit ok = 1;
    bit tgt[NB];
    for (int i = 0; i < NB; i++) tgt[i] = 0;
    if (op == 1) begin ok = (mst[b] == 0); tgt[b] = 1; end
    else if (op == 2 || op == 3) begin ok = (mst[b] >= 2 && mst[b] <= 4); tgt[b] = 1; end
    else if (op == 4 && a8 == 1) begin
      for (int i = 0; i < NB; i++) begin if (locked(mst[i])) ok = 0; tgt[i] = 1; end
    end else if (op == 4) begin ok = !locked(mst[b]); tgt[b] = 1; end
    mviol = ok ? 0 : 1;
    for (int i = 0; i < NB; i++) begin
      if (ok && tgt[i]) begin
        case (op)
          1: begin mst[i] = 1; mrem[i] = RCD; end
          2: begin mst[i] = a8 ? 5 : 3; mrem[i] = a8 ? BC + RP : BC; end
          3: begin mst[i] = a8 ? 6 : 4; mrem[i] = a8 ? BC + RP : BC; end
          default: if (mst[i] != 0) begin mst[i] = 7; mrem[i] = RP; end
        endcase
      end else if (mst[i] != 0 && mst[i] != 2) begin
        mrem[i]--;
        if (mrem[i] == 0) mst[i] = (mst[i] <= 4) ? 2 : 0;
      end
    end
  endtask

  task automatic step(input int op, input int b, input int a8);
    cmd_op = 3'(op); cmd_ba = 2'(b); cmd_a8 = a8[0];
    model_step(op, b, a8);
    @(posedge clk);
    @(negedge clk);
    check("R9 model violation", int'(violation), mviol);
    for (int i = 0; i < NB; i++) check("R2 model state", bst(i), mst[i]);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin mst[i] = 0; mrem[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NB; i++) check("R1 reset state", bst(i), 0);
    check("R1 reset violation", int'(violation), 0);

    step(2, 0, 0); check("R3 read to idle flagged", int'(violation), 1); check("R3 state kept", bst(0), 0);
    step(0, 0, 0); check("R9 pulse one cycle", int'(violation), 0);
    step(1, 0, 0); check("R2 opening", bst(0), 1);
    step(2, 0, 0); check("R6 read while opening", int'(violation), 1); check("R6 state kept", bst(0), 1);
    step(0, 0, 0); check("R2 still opening", bst(0), 1);
    step(0, 0, 0); check("R2 open after tRCD", bst(0), 2);
    step(1, 0, 0); check("R10 act on open row", int'(violation), 1); check("R10 state kept", bst(0), 2);
    step(2, 0, 0); check("R4 reading", bst(0), 3);
    step(0, 0, 0); check("R4 reading second cycle", bst(0), 3);
    step(0, 0, 0); check("R4 back to open", bst(0), 2);
    step(3, 0, 0); check("R4 writing", bst(0), 4);
    step(3, 0, 0); check("R11 restart legal", int'(violation), 0);
    step(0, 0, 0); check("R11 burst restarted", bst(0), 4);
    step(0, 0, 0); check("R11 open after restart", bst(0), 2);

    step(1, 1, 0); step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    check("R2 bank1 open", bst(1), 2);
    step(3, 1, 1); check("R5 write auto-close", bst(1), 6);
    step(4, 0, 1); check("R8 all-close refused", int'(violation), 1); check("R8 bank0 kept", bst(0), 2);
    step(2, 1, 0); check("R6 read in auto-close", int'(violation), 1);
    step(0, 0, 0); step(0, 0, 0); check("R5 still auto-close", bst(1), 6);
    step(0, 0, 0); check("R5 idle after burst plus tRP", bst(1), 0);

    step(4, 0, 0); check("R7 closing", bst(0), 7);
    step(4, 0, 0); check("R6 close while closing", int'(violation), 1);
    step(0, 0, 0); check("R7 still closing", bst(0), 7);
    step(0, 0, 0); check("R7 idle after tRP", bst(0), 0);
    step(4, 2, 0); check("R7 close idle bank quiet", int'(violation), 0); check("R7 idle kept", bst(2), 0);

    step(1, 2, 0); step(1, 3, 0); step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(4, 1, 1);
    check("R8 all-close legal", int'(violation), 0);
    check("R8 bank2 closing", bst(2), 7);
    check("R8 bank3 closing", bst(3), 7);
    check("R8 bank1 idle kept", bst(1), 0);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);

    for (int k = 0; k < 4000; k++) begin
      int r  = int'($urandom_range(0, 9));
      int op = (r < 2) ? 0 : (r < 4) ? 1 : (r < 6) ? 2 : (r < 8) ? 3 : 4;
      step(op, int'($urandom_range(0, NB - 1)), ($urandom_range(0, 9) < 3) ? 1 : 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule